// File: doc/BRIEF.md
# Register-Driven I2C Master

This block is an I2C bus master that software runs entirely through five byte-wide registers. The registers are: an own-address store, a bus-clock divider, a control register, a status register and a data port. Bus transfers are triggered by side effects of register accesses. In master mode, the first data-port write after the bus goes idle is sent as the address byte, preceded by a START. Each later write sends one data byte. In receive mode, each data-port read returns the byte latched by the previous reception and starts the reception of the next byte. At the end of each byte the block raises a pending flag. If enabled, that flag drives one interrupt line. Software clears the flag by writing zero to it.

The bus lines are open-drain. `scl_oe` and `sda_oe` pull the wire low when high, and the real wire levels come back on `scl_i` and `sda_i`. Each bit is built from four phases of `divider+1` clocks. SDA changes while SCL is low, SCL is released, and the bit is sampled just before SCL is pulled low again. Clearing the enable bit while it is set performs a soft reset that keeps only the own-address value. Slave operation and arbitration are not provided, so the arbitration-lost status bit always reads zero.

Register offsets on `reg_addr`: 0 own address, 1 divider, 2 control, 3 status, 4 data. Control bits: 7 enable, 6 interrupt enable, 5 master select, 4 transmit mode, 2 repeated start. Status bits: 7 transfer in progress, 5 bus busy, 4 arbitration lost, 1 interrupt pending, 0 no-acknowledge seen.

Top module: `i2c_reg_master`

## Requirements
- R1: After reset, every register reads 0x00, `irq` is 0, and both `scl_oe` and `sda_oe` are 0.
- R2: Write masks apply as follows: own address keeps bits 7:1 (so 0xFF reads 0xFE), the divider keeps bits 5:0 (0xFF reads 0x3F), and control keeps bits 7,6,5,4,2 (0x4B reads 0x40). Offsets 5 to 7 read 0x00, and writes to them change no register.
- R3: Writing control with bit 7 clear while bit 7 is set returns every register to its reset value except the own address. The pending flag and `irq` drop.
- R4: Status bit 5 follows control bit 5 on each control write. Clearing control bit 5 during a transfer sends a STOP and leaves both bus lines released.
- R5: In master mode with enable set, the first data write after idle sends START and then the byte MSB first: bits 7:1 are the address and bit 0 is the direction. On acknowledge, status bit 0 clears and an interrupt is raised. On no-acknowledge, status bit 0 sets, a STOP follows, and the next write is again an address byte.
- R6: After an address, a data write whose byte is not acknowledged sets status bit 0, sends a STOP and returns to the address phase. A byte that is acknowledged clears status bit 0 and raises an interrupt.
- R7: A data read in master mode with transmit mode off and an address accepted returns the previously latched byte, receives the next byte and raises an interrupt. With no address accepted, or with transmit mode on, the read returns 0xFF and starts nothing.
- R8: An interrupt sets status bit 1 and asserts `irq` only when control bits 7 and 6 are both set.
- R9: Writing 0 to status bit 1 clears it and drops `irq`. Writing 1 leaves it unchanged.
- R10: Data writes with enable clear, and data accesses with master select clear, start no bus activity and change no status bit.
- R11: Writing control bit 2 as 1 while an address is accepted sends a STOP. The bit then reads back 0, and the next data write starts a new START and address byte.
- R12: During a byte, SDA changes only while SCL is held low. SCL stays released for 2*(divider+1) clocks per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (data port reads have side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while `reg_addr` is stable |
| irq | output | 1 | Interrupt request, equal to the pending flag |
| scl_i | input | 1 | Sensed SCL wire level |
| sda_i | input | 1 | Sensed SDA wire level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The in-line assertions check five rules on every cycle. SDA is stable around every SCL-high window inside a byte. The pending flag only rises while both enable bits were set. A zero written to the pending bit always takes effect. Ignored data accesses never wake the bit engine. A repeated-start request always drops the address state and the bit. The scenarios against a behavioural slave show the rest. That covers bit order on the wire, acknowledge and no-acknowledge handling, the one-byte lag of received data, STOP release after master-select or repeated-start writes, soft-reset retention, and the measured SCL high time for a non-zero divider.

// File: rtl/i2c_reg_master.sv
module i2c_reg_master #(
  parameter int DIV_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam logic [2:0] A_OWN = 3'd0, A_DIV = 3'd1, A_CTL = 3'd2, A_STS = 3'd3, A_DAT = 3'd4;
  localparam logic [3:0] ACK_BIT = 4'd8;

  typedef enum logic [1:0] {E_IDLE, E_START, E_BITS, E_STOP} est_t;
  typedef enum logic [1:0] {K_ADDR, K_TX, K_RX} kind_t;

  logic [7:0]       own_q, rx_hold, sh;
  logic [DIV_W-1:0] div_q, cnt;
  logic             c_en, c_ien, c_msta, c_mtx, c_rsta;
  logic             ipend, rxak, addr_set, bus_own, stop_req, rx_mode;
  logic             scl_lo, sda_lo;
  est_t             est;
  kind_t            kind;
  logic [1:0]       q;
  logic [3:0]       bitn;

  wire tick      = (cnt == div_q);
  wire eng_free  = (est == E_IDLE) && !stop_req;
  wire xfer_busy = (est != E_IDLE) || stop_req;
  wire wr_ctl    = reg_wr && (reg_addr == A_CTL);
  wire soft_rst  = wr_ctl && c_en && !reg_wdata[7];
  wire dat_wr_go = reg_wr && (reg_addr == A_DAT) && c_en && c_msta && eng_free;
  wire dat_rd_go = reg_rd && (reg_addr == A_DAT) && c_msta && addr_set && !c_mtx && eng_free;
  wire byte_done = (est == E_BITS) && tick && (q == 2'd3) && (bitn == ACK_BIT);
  wire active    = addr_set || bus_own;
  wire raise_ok  = c_en && c_ien;

  assign scl_oe = scl_lo;
  assign sda_oe = sda_lo;
  assign irq    = ipend;

  always_comb begin
    case (reg_addr)
      A_OWN:   reg_rdata = own_q;
      A_DIV:   reg_rdata = 8'(div_q);
      A_CTL:   reg_rdata = {c_en, c_ien, c_msta, c_mtx, 1'b0, c_rsta, 2'b00};
      A_STS:   reg_rdata = {xfer_busy, 1'b0, c_msta, 1'b0, 2'b00, ipend, rxak};
      A_DAT:   reg_rdata = (c_msta && (!addr_set || c_mtx)) ? 8'hFF : rx_hold;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= '0; div_q <= '0; rx_hold <= '0; sh <= '0; cnt <= '0;
      {c_en, c_ien, c_msta, c_mtx, c_rsta} <= '0;
      {ipend, rxak, addr_set, bus_own, stop_req, rx_mode, scl_lo, sda_lo} <= '0;
      est <= E_IDLE; kind <= K_ADDR; q <= '0; bitn <= '0;
    end else if (soft_rst) begin
      div_q <= '0; rx_hold <= '0; sh <= '0; cnt <= '0;
      {c_en, c_ien, c_msta, c_mtx, c_rsta} <= '0;
      {ipend, rxak, addr_set, bus_own, stop_req, rx_mode, scl_lo, sda_lo} <= '0;
      est <= E_IDLE; kind <= K_ADDR; q <= '0; bitn <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_OWN: own_q <= reg_wdata & 8'hFE;
          A_DIV: div_q <= reg_wdata[DIV_W-1:0];
          A_CTL: begin
            c_en   <= reg_wdata[7];
            c_ien  <= reg_wdata[6];
            c_msta <= reg_wdata[5];
            c_mtx  <= reg_wdata[4];
            c_rsta <= reg_wdata[2] && !active;
            if ((!reg_wdata[5] || reg_wdata[2]) && active) begin
              addr_set <= 1'b0;
              stop_req <= 1'b1;
            end
          end
          A_STS: if (!reg_wdata[1]) ipend <= 1'b0;
          default: ;
        endcase
      end

      cnt <= (est == E_IDLE || tick) ? '0 : cnt + 1'b1;

      if (dat_wr_go) begin
        sh <= reg_wdata; rx_mode <= 1'b0; q <= '0; bitn <= '0;
        kind <= addr_set ? K_TX : K_ADDR;
        est  <= addr_set ? E_BITS : E_START;
      end else if (dat_rd_go) begin
        rx_mode <= 1'b1; kind <= K_RX; q <= '0; bitn <= '0; est <= E_BITS;
      end else if (est == E_IDLE) begin
        if (stop_req) begin
          if (bus_own) begin est <= E_STOP; q <= '0; end
          else stop_req <= 1'b0;
        end
      end else if (tick) begin
        q <= q + 1'b1;
        case (est)
          E_START: begin
            if (q == 2'd1) sda_lo <= 1'b1;
            if (q == 2'd3) begin scl_lo <= 1'b1; bus_own <= 1'b1; est <= E_BITS; end
          end
          E_BITS: begin
            if (q == 2'd0) sda_lo <= (bitn == ACK_BIT) ? rx_mode : (!rx_mode && !sh[7]);
            if (q == 2'd1) scl_lo <= 1'b0;
            if (q == 2'd3) begin
              scl_lo <= 1'b1;
              if (bitn != ACK_BIT) begin
                sh   <= {sh[6:0], sda_i};
                bitn <= bitn + 1'b1;
              end else begin
                est <= E_IDLE;
                case (kind)
                  K_ADDR: if (!sda_i) begin addr_set <= 1'b1; rxak <= 1'b0; if (raise_ok) ipend <= 1'b1; end
                          else begin rxak <= 1'b1; stop_req <= 1'b1; end
                  K_TX:   if (!sda_i) begin rxak <= 1'b0; if (raise_ok) ipend <= 1'b1; end
                          else begin rxak <= 1'b1; addr_set <= 1'b0; stop_req <= 1'b1; end
                  default: begin rx_hold <= sh; if (raise_ok) ipend <= 1'b1; end
                endcase
              end
            end
          end
          E_STOP: begin
            if (q == 2'd0) sda_lo <= 1'b1;
            if (q == 2'd1) scl_lo <= 1'b0;
            if (q == 2'd3) begin sda_lo <= 1'b0; bus_own <= 1'b0; stop_req <= 1'b0; est <= E_IDLE; end
          end
          default: ;
        endcase
      end
    end
  end

  // R12: inside a byte, SDA may only move while SCL is held low
  a_r12_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (est == E_BITS && $past(est == E_BITS) && sda_lo != $past(sda_lo)) |-> (scl_lo && $past(scl_lo)));

  // R8: pending flag only rises when enable and interrupt enable were set
  a_r8_raise_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ipend) |-> $past(c_en && c_ien));

  // R9: a zero written to the pending bit takes effect
  a_r9_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STS && !reg_wdata[1] && !byte_done) |=> !irq);

  // R10: ignored data writes leave the engine asleep
  a_r10_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_DAT && (!c_en || !c_msta) && eng_free) |=> (est == E_IDLE));

  // R7: reads without an address, or in transmit mode, start nothing
  a_r7_bad_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_DAT && c_msta && (c_mtx || !addr_set) && eng_free && !reg_wr) |=> (est == E_IDLE));

  // R11: repeated start drops the address state and self-clears
  a_r11_rsta_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && c_en && reg_wdata[7] && reg_wdata[2] && addr_set && !byte_done) |=> (!addr_set && !c_rsta));
endmodule

// File: tb/i2c_reg_master_test.sv
`timescale 1ns/1ps
module i2c_reg_master_test;
  localparam logic [2:0] OWN = 3'd0, DIV = 3'd1, CTL = 3'd2, STS = 3'd3, DAT = 3'd4;
  localparam logic [6:0] SLV = 7'h52;

  logic clk = 0, rst_n = 0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq, scl_oe, sda_oe, scl_w, sda_w;
  logic sl_low = 0;
  int n_chk = 0, n_fail = 0, starts = 0, scl_pulls = 0;
  int phase = 0, bcnt = 0, ridx = 0;
  logic rdm = 0;
  logic [7:0] ssh = '0, last_byte = '0;

  always #10 clk = ~clk;

  assign scl_w = ~scl_oe;
  assign sda_w = ~(sda_oe | sl_low);

  i2c_reg_master uut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_i(scl_w), .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe));

  function automatic logic [7:0] rbyte(input int i);
    case (i)
      0: return 8'hB7;
      1: return 8'hC9;
      2: return 8'hD2;
      default: return 8'hFF;
    endcase
  endfunction

  // behavioural slave: acks address SLV, nacks data 0xEE, serves rbyte() on reads
  initial forever @(negedge sda_w) if (scl_w) begin phase = 1; bcnt = 0; starts++; sl_low = 0; end
  initial forever @(posedge sda_w) if (scl_w) begin phase = 0; sl_low = 0; end
  initial forever @(posedge scl_oe) scl_pulls++;
  initial forever @(posedge scl_w) if (phase != 0 && bcnt < 9) begin
    if (bcnt < 8) ssh = {ssh[6:0], sda_w};
    bcnt++;
  end
  initial forever @(negedge scl_w) if (phase != 0) begin
    if (bcnt == 8) begin
      last_byte = ssh;
      if (phase == 1) begin
        if (ssh[7:1] == SLV) begin sl_low = 1; rdm = ssh[0]; ridx = 0; end
        else begin phase = 0; sl_low = 0; end
      end else if (phase == 2) sl_low = (ssh != 8'hEE);
      else sl_low = 0;
    end else if (bcnt == 9) begin
      bcnt = 0;
      if (phase == 3) ridx++;
      if (phase == 1) phase = rdm ? 3 : 2;
      sl_low = (phase == 3) ? !rbyte(ridx)[7] : 1'b0;
    end else if (phase == 3 && bcnt >= 1 && bcnt <= 7) begin
      sl_low = !rbyte(ridx)[7-bcnt];
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(STS, s);
      if (!s[7]) break;
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(OWN, v); check("R1 own", v, 8'h00);
    rd(DIV, v); check("R1 div", v, 8'h00);
    rd(CTL, v); check("R1 ctl", v, 8'h00);
    rd(STS, v); check("R1 sts", v, 8'h00);
    rd(DAT, v); check("R1 dat", v, 8'h00);
    check("R1 pins", {5'b0, irq, scl_oe, sda_oe}, 8'h00);
  endtask

  task automatic t_masks();
    logic [7:0] v;
    wr(OWN, 8'hFF); rd(OWN, v); check("R2 own mask", v, 8'hFE);
    wr(DIV, 8'hFF); rd(DIV, v); check("R2 div mask", v, 8'h3F);
    wr(CTL, 8'h4B); rd(CTL, v); check("R2 ctl mask", v, 8'h40);
    wr(CTL, 8'h00);
    wr(3'd6, 8'hAA); rd(3'd6, v); check("R2 undefined reads 0", v, 8'h00);
    rd(OWN, v); check("R2 own untouched", v, 8'hFE);
    rd(DIV, v); check("R2 div untouched", v, 8'h3F);
    wr(DIV, 8'h00);
  endtask

  task automatic t_addr_write();
    logic [7:0] v;
    wr(CTL, 8'hF0); rd(STS, v); check("R4 bus busy set", v, 8'h20);
    wr(DAT, 8'hA4); rd(STS, v); check("R5 transfer running", v & 8'h80, 8'h80);
    wait_idle();
    check("R5 address byte msb first", last_byte, 8'hA4);
    rd(STS, v); check("R5 ack status", v, 8'h22);
    check("R8 irq raised", {7'b0, irq}, 8'h01);
    check("R5 scl held low", {7'b0, scl_oe}, 8'h01);
    wr(STS, 8'h02); rd(STS, v); check("R9 write 1 keeps", v, 8'h22);
    wr(STS, 8'h00); rd(STS, v); check("R9 write 0 clears", v, 8'h20);
    check("R9 irq low", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_data_write();
    logic [7:0] v;
    int s0;
    wr(DAT, 8'h3C); wait_idle();
    check("R6 data byte", last_byte, 8'h3C);
    rd(STS, v); check("R6 data ack", v, 8'h22);
    wr(STS, 8'h00);
    wr(DAT, 8'hEE); wait_idle();
    rd(STS, v); check("R6 data nack", v, 8'h21);
    check("R6 bus released", {6'b0, scl_oe, sda_oe}, 8'h00);
    s0 = starts;
    wr(DAT, 8'h77); wait_idle();
    check("R6 next write is address", 8'(starts - s0), 8'h01);
    check("R5 address seen", last_byte, 8'h77);
    rd(STS, v); check("R5 address nack", v, 8'h21);
    check("R5 stop after nack", {6'b0, scl_oe, sda_oe}, 8'h00);
  endtask

  task automatic t_read();
    logic [7:0] v;
    rd(DAT, v); check("R7 no address gives FF", v, 8'hFF);
    rd(STS, v); check("R7 no address starts nothing", v, 8'h21);
    wr(DAT, 8'hA5); wait_idle();
    rd(STS, v); check("R5 read address ack", v, 8'h22);
    wr(STS, 8'h00); wr(CTL, 8'hE0);
    rd(DAT, v); check("R7 first read stale", v, 8'h00);
    wait_idle(); rd(STS, v); check("R7 reception irq", v, 8'h22);
    wr(STS, 8'h00);
    rd(DAT, v); check("R7 byte 0", v, 8'hB7);
    wait_idle(); wr(STS, 8'h00);
    wr(CTL, 8'hF0); rd(DAT, v); check("R7 transmit mode FF", v, 8'hFF);
    rd(STS, v); check("R7 transmit mode idle", v, 8'h20);
    wr(CTL, 8'hE0); rd(DAT, v); check("R7 byte 1", v, 8'hC9);
    wait_idle(); wr(STS, 8'h00);
    wr(CTL, 8'hC0); wait_idle();
    rd(STS, v); check("R4 bus busy cleared", v, 8'h00);
    check("R4 stop released bus", {6'b0, scl_oe, sda_oe}, 8'h00);
  endtask

  task automatic t_gate_rsta();
    logic [7:0] v;
    int s0;
    wr(CTL, 8'hB0); wr(DAT, 8'hA4); wait_idle();
    rd(STS, v); check("R8 no pending without ien", v, 8'h20);
    check("R8 irq stays low", {7'b0, irq}, 8'h00);
    s0 = starts;
    wr(CTL, 8'hB4); rd(CTL, v); check("R11 rsta self clears", v, 8'hB0);
    wait_idle(); check("R11 stop released bus", {6'b0, scl_oe, sda_oe}, 8'h00);
    wr(DAT, 8'hA4); wait_idle();
    check("R11 new start", 8'(starts - s0), 8'h01);
    check("R11 new address byte", last_byte, 8'hA4);
  endtask

  task automatic t_soft();
    logic [7:0] v;
    wr(OWN, 8'h34); wr(DIV, 8'h05); wr(CTL, 8'hF0);
    wr(DAT, 8'h5A); wait_idle();
    rd(STS, v); check("R6 ack before soft reset", v, 8'h22);
    wr(CTL, 8'hC0); wait_idle();
    wr(CTL, 8'h00);
    rd(OWN, v); check("R3 own kept", v, 8'h34);
    rd(DIV, v); check("R3 div cleared", v, 8'h00);
    rd(CTL, v); check("R3 ctl cleared", v, 8'h00);
    rd(STS, v); check("R3 sts cleared", v, 8'h00);
    check("R3 irq low", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    int p0;
    p0 = scl_pulls;
    wr(DAT, 8'hA4); repeat (40) @(negedge clk);
    check("R10 disabled write no bus", 8'(scl_pulls - p0), 8'h00);
    rd(STS, v); check("R10 disabled status", v, 8'h00);
    wr(CTL, 8'h90); wr(DAT, 8'hA4); repeat (40) @(negedge clk);
    check("R10 slave-mode write no bus", 8'(scl_pulls - p0), 8'h00);
    rd(DAT, v); repeat (40) @(negedge clk);
    check("R10 slave-mode read no bus", 8'(scl_pulls - p0), 8'h00);
    rd(STS, v); check("R10 slave-mode status", v, 8'h00);
  endtask

  task automatic t_timing();
    int n;
    wr(CTL, 8'hF0); wr(DIV, 8'h03); wr(DAT, 8'hA4);
    @(posedge scl_oe); @(negedge scl_oe);
    n = 0;
    forever begin
      @(negedge clk);
      if (scl_oe) break;
      n++;
    end
    check("R12 scl high clocks", 8'(n), 8'd8);
    wait_idle();
    check("R12 byte at slow clock", last_byte, 8'hA4);
    wr(CTL, 8'hC0); wait_idle();
    check("R12 bus released", {6'b0, scl_oe, sda_oe}, 8'h00);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_masks();
    t_addr_write();
    t_data_write();
    t_read();
    t_gate_rsta();
    t_soft();
    t_disabled();
    t_timing();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule